// File: doc/BRIEF.md
# DDR Bank Command Timing Enforcer

This block sits between a DDR SDRAM command scheduler and the DRAM command bus. Each cycle the scheduler offers one candidate command, made up of an opcode and a bank number. The block answers in the same cycle on `cmd_ok`. It says whether the command is legal now, given the state of every bank and the spacing rules between commands. A command is issued exactly when `cmd_valid` and `cmd_ok` are both high. On that edge the block updates its per-bank and shared counters.

All limits are given as picosecond parameters. They are converted to whole clock cycles for the configured clock period. The block keeps the following for each bank:
- an open/closed flag;
- a read/write-ready counter;
- an activate-ready counter;
- a precharge-ready counter;
- an age counter for the open row.

Three counters are shared across banks:
- spacing between activates;
- write-to-read turnaround;
- a command-bus hold after refresh or mode-register loading.

A command aimed at a bank in the wrong state is rejected and flagged on `cmd_err` in the next cycle. `ras_warn` rises when any row has stayed open close to its maximum active time.

Top module: `bank_timing_guard`

## Requirements
- R1: READ, WRITE, READ-AP and WRITE-AP to a bank are rejected until RCD_CK cycles after the ACTIVE to that bank. The ACTIVE at cycle t allows them from cycle t+RCD_CK.
- R2: PRECHARGE to an open bank is allowed from cycle max(tA+RAS_CK, tW+WR_CK). Here tA is its ACTIVE and tW is the latest WRITE to that bank.
- R3: ACTIVE to a bank is allowed from cycle max(tA+RC_CK, tP+RP_CK). Here tA is the previous ACTIVE and tP is the PRECHARGE of that bank.
- R4: ACTIVE to any bank is rejected until RRD_CK cycles after an ACTIVE to any other bank.
- R5: READ-AP at cycle t needs t+AP_DLY_CK >= tA+RAS_CK. WRITE-AP needs t+AP_DLY_CK+WR_CK >= tA+RAS_CK. After either, the bank counts as closed at once. Its next ACTIVE waits until t+offset+RP_CK, where the offset is AP_DLY_CK for READ-AP and AP_DLY_CK+WR_CK for WRITE-AP.
- R6: READ and READ-AP to any bank are rejected until WTR_CK cycles after a WRITE or WRITE-AP to any bank.
- R7: AUTO REFRESH and LOAD MODE need every bank closed and past its activate-ready point. After AUTO REFRESH no command is accepted for RFC_CK cycles. After LOAD MODE no command is accepted for MRD_CK cycles.
- R8: The following are rejected, and `cmd_err` is high in the following cycle:
  - ACTIVE to an open bank;
  - any read or write to a closed bank;
  - AUTO REFRESH or LOAD MODE while a bank is open.

  A rejection for timing alone leaves `cmd_err` low. PRECHARGE to a closed bank is accepted and has no effect.
- R9: `ras_warn` is high in cycle c exactly when some bank was open in cycle c-1 with a row age of at least RASMAX_CK-WARN_CK cycles. Row age is k in the k-th cycle after its ACTIVE.
- R10: After reset all banks are closed, `cmd_err` and `ras_warn` are low, and an ACTIVE to any bank is accepted at once.
- R11: Each picosecond limit becomes ceil(limit/CLK_PS) cycles, with at least 1. For example, 50000 ps at 8000 ps gives 7 cycles, not 6.
- R12: `cmd_op` encoding: 0 ACTIVE, 1 READ, 2 WRITE, 3 PRECHARGE, 4 READ-AP, 5 WRITE-AP, 6 AUTO REFRESH, 7 LOAD MODE. `cmd_ok` is low while `cmd_valid` is low, and such a command changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Scheduler offers a command this cycle |
| cmd_op | input | 3 | Command opcode (see R12) |
| cmd_bank | input | $clog2(BANKS) | Target bank |
| cmd_ok | output | 1 | Command is legal now; it issues on this edge |
| cmd_err | output | 1 | Previous cycle's command was rejected for bank state |
| ras_warn | output | 1 | Some open row is near its maximum active time |

## Verification
The bench builds the block with an 8000 ps clock and picosecond limits chosen to give small cycle counts:

| Limit | Cycles |
|---|---|
| RCD | 2 |
| RP | 2 |
| RAS | 5 |
| RC | 7 |
| RRD | 2 |
| WR | 2 |
| WTR | 2 |
| MRD | 2 |
| RFC | 8 |
| RASMAX | 40 (warning margin 4) |

The RC and RFC values are not whole multiples of the period, so rounding up is visible. The small counts let the bench sweep every probe delay around each limit, and every write or precharge placement relative to its ACTIVE. A 40-cycle maximum active time puts the warning edge in reach within a short run.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [2:0] {
    OP_ACT = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_PRE = 3'd3,
    OP_RDA = 3'd4,
    OP_WRA = 3'd5,
    OP_REF = 3'd6,
    OP_LMR = 3'd7
  } cmd_op_e;

  // round a picosecond limit up to whole cycles, never below one
  function automatic int ps_to_cycles(input longint t_ps, input longint clk_ps);
    longint n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return int'(n);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer
  import bank_guard_pkg::*;
#(
  parameter int CW      = 8,
  parameter int RCD_CK  = 2,
  parameter int RAS_CK  = 5,
  parameter int RC_CK   = 7,
  parameter int RP_CK   = 2,
  parameter int WR_CK   = 2,
  parameter int AP_DLY  = 2,
  parameter int WARN_AT = 36
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [2:0] op,
  output logic       active,
  output logic       rcd_ok,
  output logic       act_ok,
  output logic       pre_ok,
  output logic       ap_rd_ok,
  output logic       ap_wr_ok,
  output logic       near_max
);

  localparam logic [CW-1:0] L_RCD  = CW'(RCD_CK - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(RAS_CK - 1);
  localparam logic [CW-1:0] L_RC   = CW'(RC_CK - 1);
  localparam logic [CW-1:0] L_RP   = CW'(RP_CK - 1);
  localparam logic [CW-1:0] L_WR   = CW'(WR_CK - 1);
  localparam logic [CW-1:0] L_APRD = CW'(AP_DLY + RP_CK - 1);
  localparam logic [CW-1:0] L_APWR = CW'(AP_DLY + WR_CK + RP_CK - 1);
  localparam logic [CW-1:0] M_APRD = CW'(AP_DLY);
  localparam logic [CW-1:0] M_APWR = CW'(AP_DLY + WR_CK);
  localparam logic [CW-1:0] M_WARN = CW'(WARN_AT);

  logic [CW-1:0] rcd_c, act_c, pre_c, age;
  cmd_op_e op_e;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic [CW-1:0] vmax(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign op_e = cmd_op_e'(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      rcd_c  <= '0;
      act_c  <= '0;
      pre_c  <= '0;
      age    <= '0;
    end else begin
      rcd_c <= dec(rcd_c);
      act_c <= dec(act_c);
      pre_c <= dec(pre_c);
      if (active && age != '1) age <= age + 1'b1;
      if (issue) begin
        case (op_e)
          OP_ACT: begin
            active <= 1'b1;
            rcd_c  <= L_RCD;
            act_c  <= vmax(dec(act_c), L_RC);
            pre_c  <= L_RAS;
            age    <= CW'(1);
          end
          OP_WR: pre_c <= vmax(dec(pre_c), L_WR);
          OP_PRE: if (active) begin
            active <= 1'b0;
            act_c  <= vmax(dec(act_c), L_RP);
          end
          OP_RDA: begin
            active <= 1'b0;
            act_c  <= vmax(dec(act_c), L_APRD);
          end
          OP_WRA: begin
            active <= 1'b0;
            act_c  <= vmax(dec(act_c), L_APWR);
          end
          default: ;
        endcase
      end
    end
  end

  assign rcd_ok   = (rcd_c == '0);
  assign act_ok   = (act_c == '0);
  assign pre_ok   = (pre_c == '0);
  assign ap_rd_ok = (pre_c <= M_APRD);
  assign ap_wr_ok = (pre_c <= M_APWR);
  assign near_max = active && (age >= M_WARN);

endmodule

// File: rtl/shared_timer.sv
module shared_timer
  import bank_guard_pkg::*;
#(
  parameter int CW     = 8,
  parameter int RRD_CK = 2,
  parameter int WTR_CK = 1,
  parameter int RFC_CK = 9,
  parameter int MRD_CK = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [2:0] op,
  output logic       rrd_ok,
  output logic       wtr_ok,
  output logic       bus_ok
);

  localparam logic [CW-1:0] L_RRD = CW'(RRD_CK - 1);
  localparam logic [CW-1:0] L_WTR = CW'(WTR_CK - 1);
  localparam logic [CW-1:0] L_RFC = CW'(RFC_CK - 1);
  localparam logic [CW-1:0] L_MRD = CW'(MRD_CK - 1);

  logic [CW-1:0] rrd_c, wtr_c, bus_c;
  cmd_op_e op_e;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  assign op_e = cmd_op_e'(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_c <= '0;
      wtr_c <= '0;
      bus_c <= '0;
    end else begin
      rrd_c <= dec(rrd_c);
      wtr_c <= dec(wtr_c);
      bus_c <= dec(bus_c);
      if (issue) begin
        case (op_e)
          OP_ACT:        rrd_c <= L_RRD;
          OP_WR, OP_WRA: wtr_c <= L_WTR;
          OP_REF:        bus_c <= L_RFC;
          OP_LMR:        bus_c <= L_MRD;
          default: ;
        endcase
      end
    end
  end

  assign rrd_ok = (rrd_c == '0);
  assign wtr_ok = (wtr_c == '0);
  assign bus_ok = (bus_c == '0);

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_guard_pkg::*;
#(
  parameter int BANKS       = 4,
  parameter int CLK_PS      = 8000,
  parameter int T_RCD_PS    = 15000,
  parameter int T_RP_PS     = 15000,
  parameter int T_RAS_PS    = 42000,
  parameter int T_RASMAX_PS = 70000000,
  parameter int T_RC_PS     = 60000,
  parameter int T_RRD_PS    = 12000,
  parameter int T_WR_PS     = 15000,
  parameter int T_MRD_PS    = 12000,
  parameter int T_RFC_PS    = 72000,
  parameter int WTR_CK      = 1,
  parameter int AP_DLY_CK   = 2,
  parameter int WARN_CK     = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(BANKS)-1:0] cmd_bank,
  output logic                     cmd_ok,
  output logic                     cmd_err,
  output logic                     ras_warn
);

  localparam int BW        = $clog2(BANKS);
  localparam int RCD_CK    = ps_to_cycles(T_RCD_PS, CLK_PS);
  localparam int RP_CK     = ps_to_cycles(T_RP_PS, CLK_PS);
  localparam int RAS_CK    = ps_to_cycles(T_RAS_PS, CLK_PS);
  localparam int RASMAX_CK = ps_to_cycles(T_RASMAX_PS, CLK_PS);
  localparam int RC_CK     = ps_to_cycles(T_RC_PS, CLK_PS);
  localparam int RRD_CK    = ps_to_cycles(T_RRD_PS, CLK_PS);
  localparam int WR_CK     = ps_to_cycles(T_WR_PS, CLK_PS);
  localparam int MRD_CK    = ps_to_cycles(T_MRD_PS, CLK_PS);
  localparam int RFC_CK    = ps_to_cycles(T_RFC_PS, CLK_PS);
  localparam int WARN_AT   = imax(RASMAX_CK - WARN_CK, 1);
  localparam int MAXC      = imax(imax(RASMAX_CK, RFC_CK),
                                  imax(RC_CK, AP_DLY_CK + WR_CK + RP_CK));
  localparam int CW        = $clog2(MAXC + 2);

  logic [BANKS-1:0] bank_active, rcd_ok_v, act_ok_v, pre_ok_v;
  logic [BANKS-1:0] ap_rd_v, ap_wr_v, near_v, issue_v;
  logic rrd_ok, wtr_ok, bus_ok;
  logic state_bad, timing_ok;
  cmd_op_e op_e;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign issue_v[g] = cmd_ok && (cmd_bank == BW'(g));
    bank_timer #(
      .CW(CW), .RCD_CK(RCD_CK), .RAS_CK(RAS_CK), .RC_CK(RC_CK),
      .RP_CK(RP_CK), .WR_CK(WR_CK), .AP_DLY(AP_DLY_CK), .WARN_AT(WARN_AT)
    ) u_bank (
      .clk(clk), .rst(rst), .issue(issue_v[g]), .op(cmd_op),
      .active(bank_active[g]), .rcd_ok(rcd_ok_v[g]), .act_ok(act_ok_v[g]),
      .pre_ok(pre_ok_v[g]), .ap_rd_ok(ap_rd_v[g]), .ap_wr_ok(ap_wr_v[g]),
      .near_max(near_v[g])
    );
  end

  shared_timer #(
    .CW(CW), .RRD_CK(RRD_CK), .WTR_CK(WTR_CK), .RFC_CK(RFC_CK), .MRD_CK(MRD_CK)
  ) u_shared (
    .clk(clk), .rst(rst), .issue(cmd_ok), .op(cmd_op),
    .rrd_ok(rrd_ok), .wtr_ok(wtr_ok), .bus_ok(bus_ok)
  );

  assign op_e = cmd_op_e'(cmd_op);

  always_comb begin
    state_bad = 1'b0;
    timing_ok = 1'b0;
    case (op_e)
      OP_ACT: begin
        state_bad = bank_active[cmd_bank];
        timing_ok = act_ok_v[cmd_bank] && rrd_ok;
      end
      OP_RD: begin
        state_bad = !bank_active[cmd_bank];
        timing_ok = rcd_ok_v[cmd_bank] && wtr_ok;
      end
      OP_WR: begin
        state_bad = !bank_active[cmd_bank];
        timing_ok = rcd_ok_v[cmd_bank];
      end
      OP_PRE: begin
        timing_ok = !bank_active[cmd_bank] || pre_ok_v[cmd_bank];
      end
      OP_RDA: begin
        state_bad = !bank_active[cmd_bank];
        timing_ok = rcd_ok_v[cmd_bank] && wtr_ok && ap_rd_v[cmd_bank];
      end
      OP_WRA: begin
        state_bad = !bank_active[cmd_bank];
        timing_ok = rcd_ok_v[cmd_bank] && ap_wr_v[cmd_bank];
      end
      OP_REF, OP_LMR: begin
        state_bad = |bank_active;
        timing_ok = &act_ok_v;
      end
      default: ;
    endcase
  end

  assign cmd_ok = cmd_valid && !state_bad && timing_ok && bus_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_err  <= 1'b0;
      ras_warn <= 1'b0;
    end else begin
      cmd_err  <= cmd_valid && state_bad;
      ras_warn <= |near_v;
    end
  end

endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk #(
  parameter int BANKS  = 4,
  parameter int RCD_CK = 2,
  parameter int RAS_CK = 5,
  parameter int RRD_CK = 2,
  parameter int RFC_CK = 9,
  parameter int MRD_CK = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic [2:0]               cmd_op,
  input logic [$clog2(BANKS)-1:0] cmd_bank,
  input logic                     cmd_ok,
  input logic                     cmd_err,
  input logic                     ras_warn,
  input logic [BANKS-1:0]         bank_active
);

  // R1: no read or write right after ACTIVE to the same bank
  assert_rcd_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (RCD_CK > 1 && cmd_ok && cmd_op == 3'd0) |=>
      !(cmd_ok && cmd_op inside {3'd1, 3'd2, 3'd4, 3'd5} && cmd_bank == $past(cmd_bank)));

  // R2: no PRECHARGE right after ACTIVE to the same bank
  assert_ras_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (RAS_CK > 1 && cmd_ok && cmd_op == 3'd0) |=>
      !(cmd_ok && cmd_op == 3'd3 && cmd_bank == $past(cmd_bank)));

  // R4: two ACTIVEs never issue back to back
  assert_rrd_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (RRD_CK > 1 && cmd_ok && cmd_op == 3'd0) |=> !(cmd_ok && cmd_op == 3'd0));

  // R7: bus stays quiet after refresh or mode load
  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && ((cmd_op == 3'd6 && RFC_CK > 1) || (cmd_op == 3'd7 && MRD_CK > 1)))
      |=> !cmd_ok);

  // R8: an error flag follows only an offered, rejected command
  assert_err_source_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> ($past(cmd_valid) && !$past(cmd_ok)));

  // R9: warning only after some row was open
  assert_warn_open_R9: assert property (@(posedge clk) disable iff (rst)
    ras_warn |-> $past(|bank_active));

  // R10: outputs quiet in the first cycle out of reset
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_err && !ras_warn && bank_active == '0));

  // R12: nothing issues without an offer
  assert_ok_needs_valid_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |-> cmd_valid);

endmodule

bind bank_timing_guard bank_timing_guard_chk #(
  .BANKS(BANKS), .RCD_CK(RCD_CK), .RAS_CK(RAS_CK), .RRD_CK(RRD_CK),
  .RFC_CK(RFC_CK), .MRD_CK(MRD_CK)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_ok(cmd_ok), .cmd_err(cmd_err),
  .ras_warn(ras_warn), .bank_active(bank_active)
);

// File: tb/sim_bank_timing_guard.sv
module sim_bank_timing_guard;

  localparam int CLK     = 8000;
  localparam int P_RCD   = 15000;
  localparam int P_RP    = 15000;
  localparam int P_RAS   = 40000;
  localparam int P_RMAX  = 320000;
  localparam int P_RC    = 50000;
  localparam int P_RRD   = 12000;
  localparam int P_WR    = 15000;
  localparam int P_MRD   = 12000;
  localparam int P_RFC   = 60000;
  localparam int E_WTR   = 2;
  localparam int E_AP    = 2;
  localparam int E_WARN  = 4;

  // expected cycle counts, rounded up
  localparam int E_RCD  = (P_RCD + CLK - 1) / CLK;
  localparam int E_RP   = (P_RP + CLK - 1) / CLK;
  localparam int E_RAS  = (P_RAS + CLK - 1) / CLK;
  localparam int E_RMAX = (P_RMAX + CLK - 1) / CLK;
  localparam int E_RC   = (P_RC + CLK - 1) / CLK;
  localparam int E_RRD  = (P_RRD + CLK - 1) / CLK;
  localparam int E_WR   = (P_WR + CLK - 1) / CLK;
  localparam int E_MRD  = (P_MRD + CLK - 1) / CLK;
  localparam int E_RFC  = (P_RFC + CLK - 1) / CLK;

  localparam logic [2:0] ACT = 3'd0, RD = 3'd1, WR = 3'd2, PRE = 3'd3,
                         RDA = 3'd4, WRA = 3'd5, REF = 3'd6, LMR = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic cmd_ok, cmd_err, ras_warn;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  bit done = 1'b0;
  logic got_ok, got_err, got_warn;

  always #4 clk = ~clk;

  bank_timing_guard #(
    .BANKS(4), .CLK_PS(CLK), .T_RCD_PS(P_RCD), .T_RP_PS(P_RP), .T_RAS_PS(P_RAS),
    .T_RASMAX_PS(P_RMAX), .T_RC_PS(P_RC), .T_RRD_PS(P_RRD), .T_WR_PS(P_WR),
    .T_MRD_PS(P_MRD), .T_RFC_PS(P_RFC), .WTR_CK(E_WTR), .AP_DLY_CK(E_AP),
    .WARN_CK(E_WARN)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ok(cmd_ok), .cmd_err(cmd_err), .ras_warn(ras_warn)
  );

  task automatic cyc(input logic v, input logic [2:0] op, input logic [1:0] bk);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_bank = bk;
    #1;
    got_ok = cmd_ok; got_err = cmd_err; got_warn = ras_warn;
    cur++;
  endtask

  task automatic go(input int t);
    while (cur < t) cyc(1'b0, ACT, 2'd0);
  endtask

  task automatic restart();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cur = 0;
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state, ACTIVE to every bank accepted at once
    for (int b = 0; b < 4; b++) begin
      restart();
      cyc(1'b1, ACT, 2'(b));
      chk("R10 act after reset", got_ok, 1'b1);
      chk("R10 err low", got_err, 1'b0);
      chk("R10 warn low", got_warn, 1'b0);
    end

    // R1: read / write after ACTIVE
    for (int d = 1; d <= 4; d++) begin
      restart(); cyc(1'b1, ACT, 2'd1); go(d); cyc(1'b1, RD, 2'd1);
      chk("R1 read delay", got_ok, d >= E_RCD);
      restart(); cyc(1'b1, ACT, 2'd2); go(d); cyc(1'b1, WR, 2'd2);
      chk("R1 write delay", got_ok, d >= E_RCD);
    end

    // R2: precharge after ACTIVE
    for (int d = 1; d <= 7; d++) begin
      restart(); cyc(1'b1, ACT, 2'd0); go(d); cyc(1'b1, PRE, 2'd0);
      chk("R2 pre after act", got_ok, d >= E_RAS);
    end
    // R2: precharge after write recovery
    for (int w = 2; w <= 5; w++) begin
      for (int p = w + 1; p <= 9; p++) begin
        restart(); cyc(1'b1, ACT, 2'd0); go(w); cyc(1'b1, WR, 2'd0);
        go(p); cyc(1'b1, PRE, 2'd0);
        chk("R2 pre after write", got_ok,
            p >= ((E_RAS > w + E_WR) ? E_RAS : w + E_WR));
      end
    end

    // R3 / R11: re-activate after precharge and row cycle
    for (int pp = 5; pp <= 7; pp++) begin
      for (int q = pp + 1; q <= 10; q++) begin
        restart(); cyc(1'b1, ACT, 2'd3); go(pp); cyc(1'b1, PRE, 2'd3);
        go(q); cyc(1'b1, ACT, 2'd3);
        if (q == 6) chk("R11 rounded row cycle", got_ok, 1'b0);
        else chk("R3 reactivate", got_ok,
                 q >= ((E_RC > pp + E_RP) ? E_RC : pp + E_RP));
      end
    end

    // R4: activate spacing between banks
    for (int d = 1; d <= 3; d++) begin
      restart(); cyc(1'b1, ACT, 2'd0); go(d); cyc(1'b1, ACT, 2'd1);
      chk("R4 act to act", got_ok, d >= E_RRD);
    end

    // R5: auto precharge legality
    for (int d = 2; d <= 6; d++) begin
      restart(); cyc(1'b1, ACT, 2'd0); go(d); cyc(1'b1, RDA, 2'd0);
      chk("R5 read-ap", got_ok, d + E_AP >= E_RAS);
      restart(); cyc(1'b1, ACT, 2'd0); go(d); cyc(1'b1, WRA, 2'd0);
      chk("R5 write-ap", got_ok, d + E_AP + E_WR >= E_RAS);
    end
    // R5: activate after read-ap, bank closed at once
    for (int q = 5; q <= 10; q++) begin
      restart(); cyc(1'b1, ACT, 2'd0); go(4); cyc(1'b1, RDA, 2'd0);
      go(q); cyc(1'b1, ACT, 2'd0);
      chk("R5 act after read-ap", got_ok,
          q >= ((E_RC > 4 + E_AP + E_RP) ? E_RC : 4 + E_AP + E_RP));
    end
    restart(); cyc(1'b1, ACT, 2'd0); go(4); cyc(1'b1, RDA, 2'd0);
    cyc(1'b1, RD, 2'd0);
    chk("R5 closed after ap", got_ok, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R5 closed after ap err", got_err, 1'b1);

    // R6: write to read turnaround
    for (int k = 1; k <= 3; k++) begin
      restart(); cyc(1'b1, ACT, 2'd0); go(2); cyc(1'b1, WR, 2'd0);
      go(2 + k); cyc(1'b1, RD, 2'd0);
      chk("R6 write to read", got_ok, k >= E_WTR);
    end

    // R7: refresh and mode load hold the bus
    for (int d = 1; d <= 9; d++) begin
      restart(); cyc(1'b1, REF, 2'd0); go(d); cyc(1'b1, ACT, 2'd0);
      chk("R7 after refresh", got_ok, d >= E_RFC);
    end
    for (int d = 1; d <= 3; d++) begin
      restart(); cyc(1'b1, LMR, 2'd0); go(d); cyc(1'b1, ACT, 2'd2);
      chk("R7 after mode load", got_ok, d >= E_MRD);
    end
    for (int q = 6; q <= 8; q++) begin
      restart(); cyc(1'b1, ACT, 2'd1); go(5); cyc(1'b1, PRE, 2'd1);
      go(q); cyc(1'b1, REF, 2'd0);
      chk("R7 refresh after precharge", got_ok,
          q >= ((E_RC > 5 + E_RP) ? E_RC : 5 + E_RP));
    end
    restart(); cyc(1'b1, ACT, 2'd1); go(8); cyc(1'b1, REF, 2'd0);
    chk("R7 refresh with open bank", got_ok, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R8 refresh open bank err", got_err, 1'b1);

    // R8: state errors versus timing rejects
    restart(); cyc(1'b1, ACT, 2'd2); go(8); cyc(1'b1, ACT, 2'd2);
    chk("R8 act open bank", got_ok, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R8 act open bank err", got_err, 1'b1);
    restart(); cyc(1'b1, RD, 2'd1);
    chk("R8 read idle bank", got_ok, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R8 read idle bank err", got_err, 1'b1);
    restart(); cyc(1'b1, ACT, 2'd0); cyc(1'b1, RD, 2'd0);
    chk("R8 timing reject", got_ok, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R8 timing reject no err", got_err, 1'b0);
    restart(); cyc(1'b1, PRE, 2'd1);
    chk("R8 pre idle bank", got_ok, 1'b1);
    cyc(1'b1, ACT, 2'd1);
    chk("R8 pre idle no effect", got_ok, 1'b1);

    // R9: open-row warning
    restart(); cyc(1'b1, ACT, 2'd0);
    go(E_RMAX - E_WARN); cyc(1'b0, ACT, 2'd0);
    chk("R9 warn not yet", got_warn, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R9 warn rises", got_warn, 1'b1);
    cyc(1'b1, PRE, 2'd0);
    chk("R9 pre accepted", got_ok, 1'b1);
    cyc(1'b0, ACT, 2'd0);
    chk("R9 warn held", got_warn, 1'b1);
    cyc(1'b0, ACT, 2'd0);
    chk("R9 warn clears", got_warn, 1'b0);

    // R12: unoffered command has no effect
    restart(); cyc(1'b0, ACT, 2'd0);
    chk("R12 no ok without valid", got_ok, 1'b0);
    go(3); cyc(1'b1, RD, 2'd0);
    chk("R12 bank still idle", got_ok, 1'b0);
    cyc(1'b0, ACT, 2'd0);
    chk("R12 bank still idle err", got_err, 1'b1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule